// File: doc/BRIEF.md
# SPI Flash Command Engine

The block is an SPI master that runs one short flash transaction per trigger. A host fills a small byte-wide register window with an opcode, the low sixteen address bits and up to four data bytes. It then writes a mode byte. The upper nibble of that byte picks one of eleven fixed transaction shapes. The lower nibble gives address bits [19:16]. The write itself starts the transfer.

The engine holds chip select low for the whole transaction. It shifts bytes in SPI mode 0 with the most significant bit first. Read bytes land in the data registers, and the first byte received goes to the lowest data offset. A busy output covers the transfer. Register writes made while busy have no effect.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK is low, busy is low, and all eight window offsets read 0x00.
- R2: The window is byte addressed: offset 0 is the opcode, 1 is the mode byte, 2 is address [15:8], 3 is address [7:0], and 4 to 7 are data bytes 0 to 3. Offsets 0, 2 to 7 read back what was written.
- R3: A mode write with shape code 1 to 11 (0x1 to 0xB) raises busy on the next clock. Chip select then stays low for the whole transaction, and busy is low again once chip select returns high.
- R4: Shapes 4 to 11 send the opcode and then three address bytes: {4'h0, mode[3:0]}, offset 2, offset 3.
- R5: Shape 2 sends one write byte from offset 4 after the opcode. Shape 5 sends one write byte and shape 6 sends four write bytes (offsets 4 to 7) after the address. Write shapes leave the data registers unchanged.
- R6: Shape 3 (two bytes, no address) and shapes 8, 9, 10, 11 (1, 2, 3, 4 bytes after the address) store the received bytes from offset 4 upward, first byte lowest. The engine drives 0x00 while reading. Data offsets beyond the read count keep their values.
- R7: Shape 7 sends opcode, address, one dummy byte of 0x00, and then reads four bytes into offsets 4 to 7. The byte seen on MISO during the dummy is discarded.
- R8: A mode write with shape code 0 or 12 to 15 starts no transfer. Chip select stays high and busy stays low.
- R9: Writes to any offset while busy are ignored. The transaction in flight and the register contents are unaffected.
- R10: SCLK idles low. MOSI changes only while SCLK is low, and MISO is sampled on the SCLK rising edge. Bits go most significant first. The SCLK period is CLK_DIV system clocks.
- R11: Shapes 1 to 3 send no address bytes. Shape 1 sends only the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Window byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data at addr_i (combinational) |
| busy_o | output | 1 | Transaction in progress |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_sclk_o | output | 1 | SPI clock |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
Every one of the eleven shapes is launched with distinct opcode, address and data patterns. A bench-side flash model returns a different byte at each position. This shows which bytes were transmitted, in what order, and which received byte ended up at which offset. A byte misplaced by one position or an extra dummy shows up as a mismatch.

Before each transfer the data registers are preloaded with known values. This separates bytes that were correctly written from bytes that were wrongly overwritten or left stale. Three illegal shape codes and a burst of writes during a transfer show that the trigger decode and the busy guard do not leak.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int WIN_AW     = 3;
  localparam int DATA_REGS  = 4;
  localparam int DATA_W     = 8 * DATA_REGS;
  localparam int IDX_W      = 4;

  typedef struct packed {
    logic       valid;
    logic [1:0] n_addr;
    logic       n_dummy;
    logic [2:0] n_wr;
    logic [2:0] n_rd;
  } shape_t;

  function automatic shape_t decode_shape(input logic [3:0] code);
    shape_t s;
    s = '0;
    s.valid = 1'b1;
    case (code)
      4'h1: ;
      4'h2: s.n_wr = 3'd1;
      4'h3: s.n_rd = 3'd2;
      4'h4: s.n_addr = 2'd3;
      4'h5: begin s.n_addr = 2'd3; s.n_wr = 3'd1; end
      4'h6: begin s.n_addr = 2'd3; s.n_wr = 3'd4; end
      4'h7: begin s.n_addr = 2'd3; s.n_dummy = 1'b1; s.n_rd = 3'd4; end
      4'h8: begin s.n_addr = 2'd3; s.n_rd = 3'd1; end
      4'h9: begin s.n_addr = 2'd3; s.n_rd = 3'd2; end
      4'hA: begin s.n_addr = 2'd3; s.n_rd = 3'd3; end
      4'hB: begin s.n_addr = 2'd3; s.n_rd = 3'd4; end
      default: s.valid = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = $clog2(HALF + 1);

  logic          active_q;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;
  logic          sclk_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        tx_q     <= tx_i;
        div_q    <= '0;
        bit_q    <= '0;
        sclk_q   <= 1'b0;
      end else if (active_q) begin
        if (div_q == DW'(HALF - 1)) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              tx_q  <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = active_q & tx_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [7:0]        mode_i,
  input  logic [7:0]        opcode_i,
  input  logic [7:0]        addr_hi_i,
  input  logic [7:0]        addr_lo_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  output logic              sh_start_o,
  output logic [7:0]        sh_tx_o,
  output logic              cs_no,
  output logic              busy_o,
  output logic              rd_we_o,
  output logic [1:0]        rd_idx_o,
  output logic [7:0]        rd_byte_o
);
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT} st_e;

  st_e            st_q;
  logic [IDX_W-1:0] idx_q;
  shape_t         shp;
  logic [IDX_W-1:0] a_end, d_end, w_end, r_end, a_k, w_k, r_k;
  logic           last, is_rd;

  always_comb begin
    shp   = decode_shape(mode_i[7:4]);
    a_end = IDX_W'(1) + IDX_W'(shp.n_addr);
    d_end = a_end + IDX_W'(shp.n_dummy);
    w_end = d_end + IDX_W'(shp.n_wr);
    r_end = w_end + IDX_W'(shp.n_rd);
    a_k   = idx_q - IDX_W'(1);
    w_k   = idx_q - d_end;
    r_k   = idx_q - w_end;
    last  = (idx_q == r_end - IDX_W'(1));
    is_rd = (idx_q >= w_end);
    if (idx_q == '0)          sh_tx_o = opcode_i;
    else if (idx_q < a_end) begin
      case (a_k[1:0])
        2'd0:    sh_tx_o = {4'h0, mode_i[3:0]};
        2'd1:    sh_tx_o = addr_hi_i;
        default: sh_tx_o = addr_lo_i;
      endcase
    end
    else if (idx_q < d_end)   sh_tx_o = 8'h00;
    else if (idx_q < w_end)   sh_tx_o = data_i[{w_k[1:0], 3'b000} +: 8];
    else                      sh_tx_o = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (go_i) begin
          st_q  <= S_LOAD;
          idx_q <= '0;
        end
        S_LOAD: st_q <= S_WAIT;
        S_WAIT: if (sh_done_i) begin
          if (last) st_q <= S_IDLE;
          else begin
            idx_q <= idx_q + IDX_W'(1);
            st_q  <= S_LOAD;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign sh_start_o = (st_q == S_LOAD);
  assign cs_no      = (st_q == S_IDLE);
  assign busy_o     = (st_q != S_IDLE);
  assign rd_we_o    = (st_q == S_WAIT) && sh_done_i && is_rd;
  assign rd_idx_o   = r_k[1:0];
  assign rd_byte_o  = sh_rx_i;
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WIN_AW-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              seq_busy_i,
  input  logic              rd_we_i,
  input  logic [1:0]        rd_idx_i,
  input  logic [7:0]        rd_byte_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        opcode_o,
  output logic [7:0]        mode_o,
  output logic [7:0]        addr_hi_o,
  output logic [7:0]        addr_lo_o,
  output logic [DATA_W-1:0] data_o,
  output logic              go_o
);
  logic [7:0] opcode_q, mode_q, ahi_q, alo_q;
  logic       go_q, acc;
  shape_t     req;

  assign acc = wr_i && !(seq_busy_i || go_q);
  assign req = decode_shape(wdata_i[7:4]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_q <= '0;
      mode_q   <= '0;
      ahi_q    <= '0;
      alo_q    <= '0;
      go_q     <= 1'b0;
    end else begin
      go_q <= acc && (addr_i == 3'd1) && req.valid;
      if (acc) begin
        case (addr_i)
          3'd0: opcode_q <= wdata_i;
          3'd1: mode_q   <= wdata_i;
          3'd2: ahi_q    <= wdata_i;
          3'd3: alo_q    <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < DATA_REGS; k++) begin : g_data
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (rd_we_i && rd_idx_i == 2'(k)) q <= rd_byte_i;
      else if (acc && addr_i == WIN_AW'(4 + k)) q <= wdata_i;
    end
    assign data_o[8*k +: 8] = q;
  end

  always_comb begin
    case (addr_i)
      3'd0:    rdata_o = opcode_q;
      3'd1:    rdata_o = mode_q;
      3'd2:    rdata_o = ahi_q;
      3'd3:    rdata_o = alo_q;
      default: rdata_o = data_o[{addr_i[1:0], 3'b000} +: 8];
    endcase
  end

  assign opcode_o  = opcode_q;
  assign mode_o    = mode_q;
  assign addr_hi_o = ahi_q;
  assign addr_lo_o = alo_q;
  assign go_o      = go_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       busy_o,
  output logic       spi_cs_no,
  output logic       spi_sclk_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i
);
  logic [7:0]        opcode, mode, ahi, alo, sh_tx, sh_rx, rd_byte;
  logic [DATA_W-1:0] data;
  logic              go, seq_busy, sh_start, sh_done, rd_we;
  logic [1:0]        rd_idx;

  spi_cmd_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .seq_busy_i(seq_busy), .rd_we_i(rd_we), .rd_idx_i(rd_idx), .rd_byte_i(rd_byte),
    .rdata_o, .opcode_o(opcode), .mode_o(mode), .addr_hi_o(ahi), .addr_lo_o(alo),
    .data_o(data), .go_o(go)
  );

  spi_cmd_seq u_seq (
    .clk_i, .rst_ni, .go_i(go), .mode_i(mode), .opcode_i(opcode),
    .addr_hi_i(ahi), .addr_lo_i(alo), .data_i(data),
    .sh_done_i(sh_done), .sh_rx_i(sh_rx), .sh_start_o(sh_start), .sh_tx_o(sh_tx),
    .cs_no(spi_cs_no), .busy_o(seq_busy),
    .rd_we_o(rd_we), .rd_idx_o(rd_idx), .rd_byte_o(rd_byte)
  );

  spi_cmd_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i, .rst_ni, .start_i(sh_start), .tx_i(sh_tx), .miso_i(spi_miso_i),
    .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o), .done_o(sh_done), .rx_o(sh_rx)
  );

  assign busy_o = go | seq_busy;
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker
  import spi_cmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       busy_o,
  input logic       spi_cs_no,
  input logic       spi_sclk_o,
  input logic       spi_mosi_o
);
  shape_t s;
  assign s = decode_shape(wdata_i[7:4]);

  a_r3_cs_implies_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_cs_no |-> busy_o);

  a_r3_trigger_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd1 && !busy_o && s.valid) |=> busy_o);

  a_r8_bad_shape_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd1 && !busy_o && !s.valid) |=> (!busy_o && spi_cs_no));

  a_r10_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);

  a_r10_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sclk_o && $past(spi_sclk_o)) |-> $stable(spi_mosi_o));
endmodule

bind spi_cmd_engine spi_cmd_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .busy_o(busy_o), .spi_cs_no(spi_cs_no), .spi_sclk_o(spi_sclk_o), .spi_mosi_o(spi_mosi_o)
);

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  localparam int DIV = 4;
  logic clk = 0, rst_ni = 0, wr = 0, miso = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic busy, cs_n, sclk, mosi;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni, .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .busy_o(busy), .spi_cs_no(cs_n), .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  // flash model
  logic [7:0] resp [16];
  logic [7:0] mlog [16];
  logic [7:0] cur = 0;
  int nbytes = 0, bitc = 0, cs_falls = 0;
  time t_prev = 0, t_last = 0;

  always @(negedge cs_n) begin
    nbytes = 0; bitc = 0; cs_falls++;
    miso = resp[0][7];
  end
  always @(posedge sclk) if (!cs_n) begin
    t_prev = t_last; t_last = $time;
    cur = {cur[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      if (nbytes < 16) mlog[nbytes] = cur;
      nbytes++; bitc = 0;
    end
  end
  always @(negedge sclk) if (!cs_n && nbytes < 16) miso = resp[nbytes][3'(7 - bitc)];

  task automatic chk(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic shape_info(input logic [3:0] s, output int na, output int nd, output int nw, output int nr);
    na = (s >= 4 && s <= 11) ? 3 : 0;
    nd = (s == 7) ? 1 : 0;
    nw = (s == 2 || s == 5) ? 1 : (s == 6) ? 4 : 0;
    nr = (s == 3) ? 2 : (s == 7) ? 4 : (s >= 8 && s <= 11) ? int'(s) - 7 : 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 cs", cs_n, 1);
    chk("R1 sclk", sclk, 0);
    chk("R1 busy", busy, 0);
    for (int k = 0; k < 8; k++) begin
      rd_reg(3'(k), v);
      chk("R1 reg", v, 0);
    end
  endtask

  task automatic t_regs();
    logic [7:0] v;
    for (int k = 0; k < 8; k++) if (k != 1) wr_reg(3'(k), 8'(8'h91 + 17 * k));
    for (int k = 0; k < 8; k++) if (k != 1) begin
      rd_reg(3'(k), v);
      chk("R2 readback", v, 8'(8'h91 + 17 * k));
    end
  endtask

  task automatic run_shape(input logic [3:0] s, input string req);
    int na, nd, nw, nr, tot, p;
    logic [7:0] opc, ahi, alo, v;
    logic [3:0] top;
    logic [7:0] d [4];
    logic [7:0] exp [16];
    shape_info(s, na, nd, nw, nr);
    tot = 1 + na + nd + nw + nr;
    opc = 8'h30 + 8'(s); ahi = 8'hA0 | 8'(s); alo = 8'h0F ^ 8'(s); top = ~s;
    for (int k = 0; k < 16; k++) resp[k] = 8'(8'hC5 ^ (k * 8'h13) ^ s);
    for (int k = 0; k < 4; k++) begin
      d[k] = 8'(8'h40 + s * 4 + k);
      wr_reg(3'(4 + k), d[k]);
    end
    wr_reg(3'd0, opc); wr_reg(3'd2, ahi); wr_reg(3'd3, alo);
    wr_reg(3'd1, {s, top});
    chk({req, " R3 busy after trigger"}, busy, 1);
    wait (cs_n == 0);
    wait (cs_n == 1);
    @(negedge clk);
    chk({req, " R3 busy clear"}, busy, 0);
    p = 0;
    exp[p++] = opc;
    if (na == 3) begin exp[p++] = {4'h0, top}; exp[p++] = ahi; exp[p++] = alo; end
    if (nd == 1) exp[p++] = 8'h00;
    for (int k = 0; k < nw; k++) exp[p++] = d[k];
    for (int k = 0; k < nr; k++) exp[p++] = 8'h00;
    chk({req, " R11 byte count"}, nbytes, tot);
    for (int k = 0; k < tot && k < 16; k++) chk({req, " R4 mosi byte"}, mlog[k], exp[k]);
    for (int k = 0; k < 4; k++) begin
      rd_reg(3'(4 + k), v);
      chk({req, " R6 data reg"}, v, (k < nr) ? resp[1 + na + nd + k] : d[k]);
    end
    chk({req, " R10 sclk period"}, int'((t_last - t_prev) / 20), DIV);
  endtask

  task automatic t_bad();
    int f0;
    logic [3:0] codes [3] = '{4'h0, 4'hC, 4'hF};
    f0 = cs_falls;
    for (int k = 0; k < 3; k++) begin
      wr_reg(3'd1, {codes[k], 4'h3});
      repeat (30) @(negedge clk);
      chk("R8 no transfer", cs_falls, f0);
      chk("R8 busy low", busy, 0);
    end
  endtask

  task automatic t_busy_writes();
    logic [7:0] v;
    for (int k = 0; k < 16; k++) resp[k] = 8'h5A;
    wr_reg(3'd0, 8'h02); wr_reg(3'd2, 8'h34); wr_reg(3'd3, 8'h56);
    for (int k = 0; k < 4; k++) wr_reg(3'(4 + k), 8'(8'hD0 + k));
    wr_reg(3'd1, 8'h61);
    wait (cs_n == 0);
    wr_reg(3'd0, 8'hEE); wr_reg(3'd4, 8'h11); wr_reg(3'd2, 8'h99); wr_reg(3'd1, 8'hB0);
    wait (cs_n == 1);
    @(negedge clk);
    chk("R9 bytes sent", nbytes, 8);
    chk("R9 first data byte", mlog[4], 8'hD0);
    rd_reg(3'd0, v); chk("R9 opcode kept", v, 8'h02);
    rd_reg(3'd2, v); chk("R9 addr kept", v, 8'h34);
    rd_reg(3'd4, v); chk("R9 data kept", v, 8'hD0);
    rd_reg(3'd1, v); chk("R9 mode kept", v, 8'h61);
    repeat (20) @(negedge clk);
    chk("R9 no second start", busy, 0);
  endtask

  initial begin
    #(20 * 150000);
    nfail++; nchk++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) resp[k] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    run_shape(4'h1, "R11 shape1");
    run_shape(4'h2, "R5 shape2");
    run_shape(4'h3, "R6 shape3");
    run_shape(4'h4, "R4 shape4");
    run_shape(4'h5, "R5 shape5");
    run_shape(4'h6, "R5 shape6");
    run_shape(4'h7, "R7 shape7");
    run_shape(4'h8, "R6 shape8");
    run_shape(4'h9, "R6 shape9");
    run_shape(4'hA, "R6 shapeA");
    run_shape(4'hB, "R6 shapeB");
    t_bad();
    t_busy_writes();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule